// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drains a ring of transmit descriptors that software has prepared in system memory. Each descriptor takes 8 bytes and is owned by the hardware while its ready flag is set. When software pulses the activate input and the controller is enabled, the walker fetches the descriptor at its current pointer. It reads the buffer that descriptor names one byte at a time and collects the bytes in a local frame buffer. It then writes the descriptor back with the ready flag cleared and moves on. A descriptor flagged as the end of a frame causes the collected bytes to be streamed out on a byte bus, with a marker on the final byte.

All memory traffic goes through one request port that carries 32-bit words. The descriptor word at offset 0 holds the flags in its upper half and the byte count in its lower half. The word at offset 4 holds the buffer byte address, and bytes are numbered big-endian within each word. Single-cycle event pulses report each finished descriptor, each finished frame, and any frame that had to be cut short because it grew past the size limit. A control write can abort the walk at any time.

Top module: `txdesc_walker`

## Requirements
- R1: An activate pulse starts a walk only while the enable bit (bit 1 of the control write) is held. Otherwise no memory request is issued.
- R2: A control write with bit 0 set clears the enable bit and aborts any walk without writing back. It also discards partly gathered bytes. Later activate pulses are ignored until enable is written again, and the ring pointer is kept.
- R3: For a descriptor at address P, word P holds flags in [31:16] and length in [15:0], and word P+4 holds the buffer address. A byte at address A is read from word A with its low two bits cleared: lane [31:24] for offset 0 through [7:0] for offset 3. A request stays asserted, with a stable address, until it is acknowledged.
- R4: If a fetched descriptor has flag bit 15 (ready) clear, the walk stops with no write-back, and the pointer stays on that descriptor.
- R5: Every descriptor that is processed is written back to word P with bit 15 cleared and all other flag and length bits unchanged, and ev_buf pulses for one cycle.
- R6: After a descriptor with flag bit 13 (wrap) is processed, the next fetch is at the ring base; otherwise it is at P+8.
- R7: On a descriptor with flag bit 11 (last), the gathered bytes are streamed in fetch order, out_last marks the final byte, and ev_frame pulses together with ev_buf.
- R8: Buffers from consecutive descriptors without the last flag are joined into one frame, each in address order.
- R9: A frame is capped at FRAME_MAX bytes (2032 by default). A buffer that would cross the cap is taken only up to the cap, later buffers of the same frame add nothing, and each such descriptor raises ev_babble together with ev_buf.
- R10: A ring-base write clears the two low address bits and reloads the current pointer with the result.
- R11: After reset the enable bit is clear and mem_req, out_valid and all event outputs are low.
- R12: A last-flagged descriptor that ends a frame of zero bytes streams nothing but still pulses ev_frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 2 | Control value: bit 1 enable, bit 0 soft reset |
| ring_we | input | 1 | Ring-base write strobe |
| ring_wdata | input | AW | Ring-base address |
| kick | input | 1 | Activate pulse |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word-aligned request address |
| mem_wdata | output | 32 | Write data (descriptor write-back) |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Stream byte valid |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of a frame |
| ev_buf | output | 1 | Descriptor processed pulse |
| ev_frame | output | 1 | Frame completed pulse |
| ev_babble | output | 1 | Frame length capped pulse |

## Verification
Two-descriptor frames are run over every pair of lengths from 0 to 6. The buffer start addresses vary, so all byte lanes are exercised. This shows gathering and ordering apart from per-descriptor counting, and it covers the empty-frame case. Total lengths that straddle a reduced size cap, plus a three-buffer frame that keeps growing after the cap, tell an exact trim apart from an off-by-one and from a cap that is never reset. Wrapped rings, not-ready stops, disabled activation and a mid-walk abort show whether the pointer, ownership and accumulator are kept or discarded.

// File: rtl/txdw_pkg.sv
`timescale 1ns/1ps
package txdw_pkg;
  localparam int FLG_READY  = 15;
  localparam int FLG_WRAP   = 13;
  localparam int FLG_LAST   = 11;
  localparam int DESC_BYTES = 8;
  localparam int PTR_OFFS   = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_HDR,
    ST_PTR,
    ST_DATA,
    ST_WB,
    ST_SEND
  } walk_st_t;

  // big-endian byte lane pick
  function automatic logic [7:0] be_lane(input logic [31:0] w, input logic [1:0] off);
    logic [7:0] b;
    case (off)
      2'd0:    b = w[31:24];
      2'd1:    b = w[23:16];
      2'd2:    b = w[15:8];
      default: b = w[7:0];
    endcase
    return b;
  endfunction
endpackage

// File: rtl/txdw_ctl.sv
`timescale 1ns/1ps
module txdw_ctl
  import txdw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_we,
  input  logic [1:0]    ctrl_wdata,
  input  logic          ring_we,
  input  logic [AW-1:0] ring_wdata,
  input  logic          kick,
  input  logic          adv,
  input  logic          adv_wrap,
  output logic          sreset,
  output logic          start,
  output logic [AW-1:0] cur_ptr
);
  logic          en_q;
  logic [AW-1:0] base_q;
  logic [AW-1:0] ring_al;

  assign ring_al = ring_wdata & ~AW'(3);
  assign sreset  = ctrl_we & ctrl_wdata[0];
  assign start   = kick & en_q & ~sreset;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      base_q  <= '0;
      cur_ptr <= '0;
    end else begin
      if (ctrl_we) en_q <= ctrl_wdata[0] ? 1'b0 : ctrl_wdata[1];
      if (ring_we) begin
        base_q  <= ring_al;
        cur_ptr <= ring_al;
      end else if (adv) begin
        cur_ptr <= adv_wrap ? base_q : cur_ptr + AW'(DESC_BYTES);
      end
    end
  end

  assert_ring_reload_R10: assert property (@(posedge clk) disable iff (rst)
    ring_we |=> (cur_ptr == base_q) && (cur_ptr[1:0] == 2'b00));

  assert_wrap_to_base_R6: assert property (@(posedge clk) disable iff (rst)
    adv && adv_wrap && !ring_we |=> cur_ptr == $past(base_q));

  assert_sreset_disables_R2: assert property (@(posedge clk) disable iff (rst)
    ctrl_we && ctrl_wdata[0] |=> !en_q);
endmodule

// File: rtl/txdw_fbuf.sv
`timescale 1ns/1ps
module txdw_fbuf #(
  parameter int DEPTH  = 2032,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rq
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rq <= mem[raddr];
  end

  assert_waddr_in_range_R9: assert property (@(posedge clk) disable iff (rst)
    we |-> int'(waddr) < DEPTH);
endmodule

// File: rtl/txdw_seq.sv
`timescale 1ns/1ps
module txdw_seq
  import txdw_pkg::*;
#(
  parameter int AW        = 32,
  parameter int FRAME_MAX = 2032,
  parameter int CW        = $clog2(FRAME_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sreset,
  input  logic          start,
  input  logic [AW-1:0] cur_ptr,
  output logic          adv,
  output logic          adv_wrap,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          fb_we,
  output logic [CW-1:0] fb_waddr,
  output logic [7:0]    fb_wdata,
  output logic          fb_re,
  output logic [CW-1:0] fb_raddr,
  output logic          out_valid,
  output logic          out_last,
  output logic          ev_buf,
  output logic          ev_frame,
  output logic          ev_babble
);
  walk_st_t      st;
  logic [15:0]   flags;
  logic [15:0]   len;
  logic [AW-1:0] bptr;
  logic [15:0]   left;
  logic          bab;
  logic [CW-1:0] acc;
  logic [CW-1:0] snd;

  logic [16:0]   sum;
  logic          over;
  logic [CW-1:0] room;
  logic [15:0]   take;
  logic [31:0]   wb_word;
  logic [AW-1:0] bptr_nx;
  logic          snd_end;

  assign sum     = 17'(len) + 17'(acc);
  assign over    = sum > 17'(FRAME_MAX);
  assign room    = CW'(FRAME_MAX) - acc;
  assign take    = over ? 16'(room) : len;
  assign wb_word = {flags & ~(16'(1) << FLG_READY), len};
  assign bptr_nx = bptr + AW'(1);
  assign snd_end = (snd == acc - CW'(1));

  assign adv      = (st == ST_WB) && mem_ack && !sreset;
  assign adv_wrap = flags[FLG_WRAP];

  assign fb_we    = (st == ST_DATA) && mem_ack && !sreset;
  assign fb_waddr = acc;
  assign fb_wdata = be_lane(mem_rdata, bptr[1:0]);
  assign fb_re    = (st == ST_SEND);
  assign fb_raddr = snd;

  always_ff @(posedge clk) begin
    if (rst || sreset) begin
      st        <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      flags     <= '0;
      len       <= '0;
      bptr      <= '0;
      left      <= '0;
      bab       <= 1'b0;
      acc       <= '0;
      snd       <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      ev_buf    <= 1'b0;
      ev_frame  <= 1'b0;
      ev_babble <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      ev_buf    <= 1'b0;
      ev_frame  <= 1'b0;
      ev_babble <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) st <= ST_ISSUE;
        ST_ISSUE: begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= cur_ptr;
          st       <= ST_HDR;
        end
        ST_HDR: if (mem_ack) begin
          flags <= mem_rdata[31:16];
          len   <= mem_rdata[15:0];
          if (mem_rdata[16+FLG_READY]) begin
            mem_addr <= cur_ptr + AW'(PTR_OFFS);
            st       <= ST_PTR;
          end else begin
            mem_req <= 1'b0;
            st      <= ST_IDLE;
          end
        end
        ST_PTR: if (mem_ack) begin
          bptr <= mem_rdata[AW-1:0];
          left <= take;
          bab  <= over;
          if (take == 16'd0) begin
            mem_we    <= 1'b1;
            mem_addr  <= cur_ptr;
            mem_wdata <= wb_word;
            st        <= ST_WB;
          end else begin
            mem_addr <= {mem_rdata[AW-1:2], 2'b00};
            st       <= ST_DATA;
          end
        end
        ST_DATA: if (mem_ack) begin
          acc  <= acc + CW'(1);
          bptr <= bptr_nx;
          left <= left - 16'd1;
          if (left == 16'd1) begin
            mem_we    <= 1'b1;
            mem_addr  <= cur_ptr;
            mem_wdata <= wb_word;
            st        <= ST_WB;
          end else begin
            mem_addr <= {bptr_nx[AW-1:2], 2'b00};
          end
        end
        ST_WB: if (mem_ack) begin
          mem_req   <= 1'b0;
          mem_we    <= 1'b0;
          ev_buf    <= 1'b1;
          ev_frame  <= flags[FLG_LAST];
          ev_babble <= bab;
          if (flags[FLG_LAST] && acc != '0) begin
            snd <= '0;
            st  <= ST_SEND;
          end else begin
            st <= ST_ISSUE;
          end
        end
        ST_SEND: begin
          out_valid <= 1'b1;
          out_last  <= snd_end;
          snd       <= snd + CW'(1);
          if (snd_end) begin
            acc <= '0;
            st  <= ST_ISSUE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_req_held_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack && !sreset |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_wb_ready_clear_R5: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> !mem_wdata[16+FLG_READY]);

  assert_frame_with_buf_R7: assert property (@(posedge clk) disable iff (rst)
    ev_frame |-> ev_buf);

  assert_last_is_valid_R7: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  assert_acc_capped_R9: assert property (@(posedge clk) disable iff (rst)
    acc <= CW'(FRAME_MAX));

  assert_babble_with_buf_R9: assert property (@(posedge clk) disable iff (rst)
    ev_babble |-> ev_buf);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) && !start |=> !mem_req);
endmodule

// File: rtl/txdesc_walker.sv
`timescale 1ns/1ps
module txdesc_walker #(
  parameter int AW        = 32,
  parameter int FRAME_MAX = 2032
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_we,
  input  logic [1:0]    ctrl_wdata,
  input  logic          ring_we,
  input  logic [AW-1:0] ring_wdata,
  input  logic          kick,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          ev_buf,
  output logic          ev_frame,
  output logic          ev_babble
);
  localparam int CW = $clog2(FRAME_MAX + 1);

  logic          sreset;
  logic          start;
  logic [AW-1:0] cur_ptr;
  logic          adv;
  logic          adv_wrap;
  logic          fb_we;
  logic [CW-1:0] fb_waddr;
  logic [7:0]    fb_wdata;
  logic          fb_re;
  logic [CW-1:0] fb_raddr;

  txdw_ctl #(.AW(AW)) ctl_i (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .ring_we    (ring_we),
    .ring_wdata (ring_wdata),
    .kick       (kick),
    .adv        (adv),
    .adv_wrap   (adv_wrap),
    .sreset     (sreset),
    .start      (start),
    .cur_ptr    (cur_ptr)
  );

  txdw_seq #(.AW(AW), .FRAME_MAX(FRAME_MAX), .CW(CW)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .sreset    (sreset),
    .start     (start),
    .cur_ptr   (cur_ptr),
    .adv       (adv),
    .adv_wrap  (adv_wrap),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .fb_we     (fb_we),
    .fb_waddr  (fb_waddr),
    .fb_wdata  (fb_wdata),
    .fb_re     (fb_re),
    .fb_raddr  (fb_raddr),
    .out_valid (out_valid),
    .out_last  (out_last),
    .ev_buf    (ev_buf),
    .ev_frame  (ev_frame),
    .ev_babble (ev_babble)
  );

  txdw_fbuf #(.DEPTH(FRAME_MAX), .ADDR_W(CW)) fbuf_i (
    .clk   (clk),
    .rst   (rst),
    .we    (fb_we),
    .waddr (fb_waddr),
    .wdata (fb_wdata),
    .re    (fb_re),
    .raddr (fb_raddr),
    .rq    (out_data)
  );
endmodule

// File: tb/txdesc_walker_tb_top.sv
`timescale 1ns/1ps
module txdesc_walker_tb_top;
  localparam int FMAX = 40;
  localparam logic [15:0] RDY = 16'h8000;
  localparam logic [15:0] WRP = 16'h2000;
  localparam logic [15:0] LST = 16'h0800;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_we = 1'b0;
  logic [1:0]  ctrl_wdata = 2'b00;
  logic        ring_we = 1'b0;
  logic [31:0] ring_wdata = '0;
  logic        kick = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mack;
  logic [31:0] mrd;
  logic        out_valid, out_last;
  logic [7:0]  out_data;
  logic        ev_buf, ev_frame, ev_babble;

  always #10 clk = ~clk;

  txdesc_walker #(.AW(32), .FRAME_MAX(FMAX)) dut_i (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ring_we(ring_we), .ring_wdata(ring_wdata), .kick(kick),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mack), .mem_rdata(mrd),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .ev_buf(ev_buf), .ev_frame(ev_frame), .ev_babble(ev_babble)
  );

  // memory model: 1 KB, ack one cycle after a fresh request
  logic [31:0] memw [256];
  always @(posedge clk) begin
    if (rst) mack <= 1'b0;
    else begin
      mack <= mem_req && !mack;
      if (mem_req && !mack) begin
        if (mem_we) memw[mem_addr[9:2]] <= mem_wdata;
        else        mrd <= memw[mem_addr[9:2]];
      end
    end
  end

  // monitor
  int n_tests = 0, n_fail = 0;
  logic [7:0] rxb [256];
  int rx_n, lasts, last_pos, n_buf, n_frm, n_bab, req_cyc;
  bit seen_rd;
  logic [31:0] first_addr;
  bit done = 1'b0;

  always @(negedge clk) if (!rst) begin
    if (mem_req) begin
      req_cyc++;
      if (!seen_rd && !mem_we) begin seen_rd = 1'b1; first_addr = mem_addr; end
    end
    if (out_valid) begin
      if (rx_n < 256) rxb[rx_n] = out_data;
      rx_n++;
      if (out_last) begin lasts++; last_pos = rx_n; end
    end
    if (ev_buf) n_buf++;
    if (ev_frame) n_frm++;
    if (ev_babble) n_bab++;
  end

  // expected model
  logic [7:0] expb [256];
  int exp_n, exp_bab, exp_lasts, facc, fbytes;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 13 + 7) ^ (a >> 3));
  endfunction

  task automatic clr();
    rx_n = 0; lasts = 0; last_pos = 0; n_buf = 0; n_frm = 0; n_bab = 0;
    req_cyc = 0; seen_rd = 1'b0; first_addr = '0;
    exp_n = 0; exp_bab = 0; exp_lasts = 0;
  endtask

  task automatic exp_desc(input int len, input int bufa, input bit last);
    int take;
    take = len;
    if (facc + len > FMAX) begin take = FMAX - facc; exp_bab++; end
    for (int k = 0; k < take; k++) begin expb[exp_n] = pat(bufa + k); exp_n++; end
    facc += take; fbytes += take;
    if (last) begin
      if (fbytes > 0) exp_lasts++;
      facc = 0; fbytes = 0;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic chk_stream(input string tag);
    int mism;
    mism = 0;
    for (int i = 0; i < exp_n && i < rx_n; i++) if (rxb[i] !== expb[i]) mism++;
    chk(rx_n == exp_n && mism == 0, {tag, " stream bytes"}, rx_n * 1000 + mism, exp_n * 1000);
    chk(lasts == exp_lasts && (exp_lasts == 0 || last_pos == exp_n), {tag, " last marker"},
        lasts * 1000 + last_pos, exp_lasts * 1000 + (exp_lasts == 0 ? 0 : exp_n));
  endtask

  task automatic put_desc(input int a, input logic [15:0] fl, input int len, input int bufa);
    memw[a >> 2]       = {fl, 16'(len)};
    memw[(a >> 2) + 1] = 32'(bufa);
  endtask

  task automatic wr_ctrl(input logic [1:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr_ring(input logic [31:0] v);
    @(negedge clk); ring_we = 1'b1; ring_wdata = v;
    @(negedge clk); ring_we = 1'b0;
  endtask

  task automatic pulse_kick();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic wait_quiet();
    int q;
    q = 0;
    for (int i = 0; i < 3000 && q < 6; i++) begin
      @(negedge clk);
      if (!mem_req && !out_valid) q++; else q = 0;
    end
  endtask

  task automatic walk();
    pulse_kick();
    wait_quiet();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) memw[i] = '0;
    for (int a = 'h100; a < 'h400; a++) memw[a >> 2][8 * (3 - (a & 3)) +: 8] = pat(a);
    facc = 0; fbytes = 0;
    clr();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!mem_req && !out_valid, "R11 req/valid low", {mem_req, out_valid}, 0);
    chk(!ev_buf && !ev_frame && !ev_babble, "R11 events low", {ev_buf, ev_frame, ev_babble}, 0);

    // R1 activate ignored when disabled
    put_desc(0, RDY | LST, 4, 'h100);
    put_desc(8, 16'h0, 0, 0);
    wr_ring(0);
    clr();
    pulse_kick();
    repeat (20) @(negedge clk);
    chk(req_cyc == 0 && rx_n == 0, "R1 no request while disabled", req_cyc, 0);
    chk(memw[0][31] == 1'b1, "R1 descriptor untouched", memw[0][31], 1);

    // R10 aligned reload, R3 layout and lanes, R7, R5
    wr_ctrl(2'b10);
    wr_ring('h43);
    put_desc('h40, RDY | LST, 5, 'h103);
    put_desc('h48, 16'h0, 0, 0);
    clr(); exp_desc(5, 'h103, 1'b1);
    walk();
    chk(first_addr == 'h40, "R10 first fetch at aligned base", first_addr, 'h40);
    chk_stream("R3 R7 single buffer");
    chk(n_buf == 1 && n_frm == 1 && n_bab == 0, "R7 events", n_buf * 100 + n_frm * 10 + n_bab, 110);
    chk(memw['h40 >> 2] == {LST, 16'd5}, "R5 write-back word", memw['h40 >> 2], {LST, 16'd5});
    chk(memw['h48 >> 2] == 32'h0, "R4 not-ready descriptor kept", memw['h48 >> 2], 0);

    // R4 pointer kept on not-ready descriptor
    put_desc('h48, RDY | LST, 3, 'h1F0);
    put_desc('h50, 16'h0, 0, 0);
    clr(); exp_desc(3, 'h1F0, 1'b1);
    walk();
    chk(first_addr == 'h48, "R4 resumes at stopped descriptor", first_addr, 'h48);
    chk_stream("R4 resumed frame");

    // R8 sweep of two-buffer frames (includes R12 empty frames)
    for (int a = 0; a <= 6; a++) begin
      for (int b = 0; b <= 6; b++) begin
        wr_ring(0);
        put_desc(0, RDY, a, 'h100 + a * 3);
        put_desc(8, RDY | LST, b, 'h201 + b);
        put_desc(16, 16'h0, 0, 0);
        clr();
        exp_desc(a, 'h100 + a * 3, 1'b0);
        exp_desc(b, 'h201 + b, 1'b1);
        walk();
        chk_stream("R8 gather");
        chk(n_buf == 2 && n_frm == 1 && n_bab == 0, "R5 per-descriptor events",
            n_buf * 100 + n_frm * 10 + n_bab, 210);
        chk(memw[0] == {16'h0, 16'(a)} && memw[2] == {LST, 16'(b)}, "R5 ready cleared",
            memw[0][31] + memw[2][31], 0);
        if (a + b == 0)
          chk(rx_n == 0 && n_frm == 1, "R12 empty frame", rx_n * 10 + n_frm, 1);
      end
    end

    // R6 wrap
    wr_ring('h80);
    put_desc('h80, RDY | LST, 2, 'h300);
    put_desc('h88, RDY | LST | WRP, 3, 'h310);
    put_desc('h90, RDY | LST, 1, 'h330);
    clr();
    exp_desc(2, 'h300, 1'b1);
    exp_desc(3, 'h310, 1'b1);
    walk();
    chk_stream("R6 two frames before wrap");
    chk(n_frm == 2, "R6 frame count", n_frm, 2);
    put_desc('h80, RDY | LST, 4, 'h320);
    clr(); exp_desc(4, 'h320, 1'b1);
    walk();
    chk_stream("R6 after wrap");
    chk(memw['h90 >> 2][31] == 1'b1, "R6 descriptor past wrap not fetched", memw['h90 >> 2][31], 1);

    // R9 cap sweep, then a normal frame afterwards
    for (int t = 36; t <= 44; t++) begin
      wr_ring(0);
      put_desc(0, RDY, 20, 'h100);
      put_desc(8, RDY | LST, t - 20, 'h180);
      put_desc(16, RDY | LST, 3, 'h200);
      put_desc(24, 16'h0, 0, 0);
      clr();
      exp_desc(20, 'h100, 1'b0);
      exp_desc(t - 20, 'h180, 1'b1);
      exp_desc(3, 'h200, 1'b1);
      walk();
      chk_stream("R9 capped frame then normal");
      chk(n_bab == exp_bab, "R9 babble count", n_bab, exp_bab);
    end

    // R9 growth after the cap inside one frame
    wr_ring(0);
    put_desc(0, RDY, 30, 'h100);
    put_desc(8, RDY, 15, 'h140);
    put_desc(16, RDY | LST, 5, 'h180);
    put_desc(24, 16'h0, 0, 0);
    clr();
    exp_desc(30, 'h100, 1'b0);
    exp_desc(15, 'h140, 1'b0);
    exp_desc(5, 'h180, 1'b1);
    walk();
    chk_stream("R9 three buffers over cap");
    chk(n_bab == 2 && n_buf == 3, "R9 babble on each over-cap descriptor", n_bab * 10 + n_buf, 23);

    // R2 abort mid-walk
    wr_ring(0);
    put_desc(0, RDY | LST, 30, 'h100);
    put_desc(8, 16'h0, 0, 0);
    clr();
    pulse_kick();
    repeat (12) @(negedge clk);
    wr_ctrl(2'b01);
    clr();
    repeat (20) @(negedge clk);
    chk(req_cyc == 0 && rx_n == 0, "R2 walk aborted", req_cyc * 1000 + rx_n, 0);
    chk(memw[0][31] == 1'b1, "R2 no write-back on abort", memw[0][31], 1);
    clr();
    pulse_kick();
    repeat (20) @(negedge clk);
    chk(req_cyc == 0, "R2 activate ignored after reset", req_cyc, 0);
    wr_ctrl(2'b10);
    clr(); exp_desc(30, 'h100, 1'b1);
    walk();
    chk(first_addr == 0, "R2 pointer kept", first_addr, 0);
    chk_stream("R2 partial bytes discarded");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule